// File: doc/BRIEF.md
# NOR Flash Command Sequence Decoder

This block is the command front end of a byte-wide parallel NOR flash model. It watches a synchronous stream of bus-write events, each made of a strobe, an address and a data byte. It finds the multi-write unlock handshakes that start read/reset, program, chip erase, block erase, suspend and resume. It also handles a shortcut mode in which the two unlock writes are skipped. When a sequence completes, the block raises a command pulse for exactly one cycle. The pulse carries an opcode, the address and data of the final write, and, for block erase, a mask of the selected blocks.

Block erase collects its target blocks during an acceptance window of a fixed length, counted in clock cycles from the first block selection. Any write that does not fit the sequence in progress drops the interface back to read mode. The array, the electrical timing and the embedded program/erase algorithm sit outside this block. A busy input stands in for them. While busy is high, the only write that has any effect is the suspend request.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset `cmd_valid_o`, `cmd_op_o`, `cmd_mask_o`, `bypass_o` and `suspended_o` are all zero, and the interface is in read mode.
- R2: Program takes four writes: AAh at low address AAAh, then 55h at low address 555h, then A0h at AAAh, then any address and data. The cycle after the fourth write, the block emits one pulse with `cmd_op_o`=1 carrying that address and data. The unlock and command addresses are compared on `addr_i[11:0]` only.
- R3: Chip erase takes six writes: the two unlock writes, 80h at AAAh, the two unlock writes again, then 10h at AAAh. It emits one pulse with `cmd_op_o`=2, carrying the address and data of the last write.
- R4: Block erase is the same as R3 except for the sixth write, which is 30h at any address. The block index is `addr_i[24:17]`, giving 256 blocks. The erase pulse has `cmd_op_o`=3, address 0 and data 30h. `cmd_mask_o` has bit n set for each selected block n, and `cmd_mask_o` is zero on every other opcode.
- R5: The first 30h write, sampled at edge N, opens a window of WIN_CYC cycles. A further 30h write sampled at edges N+1 to N+WIN_CYC-1 adds its block to the mask. The block-erase pulse is visible after edge N+WIN_CYC, and a write sampled at that edge or later is not added.
- R6: A write that does not fit the sequence in progress returns the interface to read mode and produces no pulse. The full unlock handshake is then needed again.
- R7: The writes AAh@AAAh, 55h@555h, 20h@AAAh enter bypass mode, and `bypass_o` goes to 1. In bypass mode, A0h at any address followed by one write emits a program pulse (`cmd_op_o`=1), and the interface stays in bypass mode.
- R8: In bypass mode, 80h followed by 10h at any address emits chip erase (`cmd_op_o`=2). 80h followed by 30h starts a block erase as in R4/R5. The interface returns to bypass mode afterwards.
- R9: When busy is low, a single F0h write at any address in any state emits a reset pulse (`cmd_op_o`=6) with that address and data. It returns the interface to read mode, clears `bypass_o`, and cancels an open block-erase window without an erase pulse.
- R10: While `busy_i` is high, writes other than B0h change nothing. B0h when not already suspended emits a suspend pulse (`cmd_op_o`=4) and sets `suspended_o`. A sequence in progress survives the busy period.
- R11: In read or bypass idle state, a 30h write while suspended emits a resume pulse (`cmd_op_o`=5) and clears `suspended_o`. When not suspended, 30h in read mode produces nothing.
- R12: In bypass mode, a write other than A0h, 80h, F0h or a resume is invalid. It leaves bypass mode, and `bypass_o` goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus-write event strobe, one cycle per write |
| addr_i | input | ADDR_W | Write address (byte address) |
| data_i | input | 8 | Write data |
| busy_i | input | 1 | Embedded algorithm running |
| cmd_valid_o | output | 1 | One-cycle command pulse |
| cmd_op_o | output | 3 | Command opcode |
| cmd_addr_o | output | ADDR_W | Command address |
| cmd_data_o | output | 8 | Command data |
| cmd_mask_o | output | 2**BLK_W | Block-erase selection mask |
| bypass_o | output | 1 | Unlock-bypass mode active |
| suspended_o | output | 1 | Operation suspended |

## Verification
A wrong sequence state shows up at the ports as a missing, extra or wrongly coded pulse. This appears one cycle after the final write of the next command. The scoreboard treats any pulse it did not predict as a mismatch. A fault in the erase window shows as a mask with a wrong bit, or as a pulse that comes too early or too late. This is pinned by writes sampled exactly at the last accepting edge and at the expiry edge. Errors in the mode flags appear directly on `bypass_o` and `suspended_o`, which are checked after each mode change.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_PROG   = 3'd1,
    OP_CHIP   = 3'd2,
    OP_BLOCK  = 3'd3,
    OP_SUSP   = 3'd4,
    OP_RESUME = 3'd5,
    OP_RESET  = 3'd6
  } op_e;

  typedef enum logic [3:0] {
    ST_READ, ST_U1, ST_U2, ST_PROG, ST_E3, ST_E4, ST_E5,
    ST_BWIN, ST_BYP, ST_BPROG, ST_BERASE
  } seq_e;

  localparam int unsigned CMD_AW = 12;
  localparam logic [CMD_AW-1:0] A_KEY1 = 12'hAAA;
  localparam logic [CMD_AW-1:0] A_KEY2 = 12'h555;
  localparam logic [7:0] D_KEY1   = 8'hAA;
  localparam logic [7:0] D_KEY2   = 8'h55;
  localparam logic [7:0] D_PROG   = 8'hA0;
  localparam logic [7:0] D_ERASE  = 8'h80;
  localparam logic [7:0] D_CHIP   = 8'h10;
  localparam logic [7:0] D_BLK    = 8'h30;
  localparam logic [7:0] D_BYPASS = 8'h20;
  localparam logic [7:0] D_RESET  = 8'hF0;
  localparam logic [7:0] D_SUSP   = 8'hB0;

  typedef struct packed {
    logic key1;
    logic key2;
    logic at_cmd;
    logic d_prog;
    logic d_erase;
    logic d_chip;
    logic d_blk;
    logic d_bypass;
    logic d_reset;
    logic d_susp;
  } cyc_t;
endpackage

// File: rtl/nor_cmd_classify.sv
module nor_cmd_classify
  import nor_cmd_pkg::*;
(
  input  logic [CMD_AW-1:0] addr_lo_i,
  input  logic [7:0]        data_i,
  output cyc_t              cyc_o
);
  always_comb begin
    cyc_o.at_cmd   = (addr_lo_i == A_KEY1);
    cyc_o.key1     = (addr_lo_i == A_KEY1) && (data_i == D_KEY1);
    cyc_o.key2     = (addr_lo_i == A_KEY2) && (data_i == D_KEY2);
    cyc_o.d_prog   = (data_i == D_PROG);
    cyc_o.d_erase  = (data_i == D_ERASE);
    cyc_o.d_chip   = (data_i == D_CHIP);
    cyc_o.d_blk    = (data_i == D_BLK);
    cyc_o.d_bypass = (data_i == D_BYPASS);
    cyc_o.d_reset  = (data_i == D_RESET);
    cyc_o.d_susp   = (data_i == D_SUSP);
  end
endmodule

// File: rtl/nor_erase_window.sv
module nor_erase_window #(
  parameter int BLK_W   = 8,
  parameter int WIN_CYC = 64,
  localparam int NUM_BLK = 1 << BLK_W,
  localparam int CNT_W   = $clog2(WIN_CYC + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               add_i,
  input  logic               cancel_i,
  input  logic               hold_i,
  input  logic [BLK_W-1:0]   blk_i,
  output logic               active_o,
  output logic               expire_o,
  output logic [NUM_BLK-1:0] mask_o
);
  logic               active_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [NUM_BLK-1:0] mask_q;
  logic [NUM_BLK-1:0] sel;

  always_comb begin
    sel = '0;
    sel[blk_i] = 1'b1;
  end

  // counter freezes while the algorithm reports busy
  assign expire_o = active_q && !hold_i && (cnt_q == CNT_W'(WIN_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      mask_q   <= '0;
    end else if (cancel_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      mask_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      mask_q   <= sel;
    end else if (active_q) begin
      if (expire_o) begin
        active_q <= 1'b0;
      end else begin
        if (!hold_i) cnt_q <= cnt_q + 1'b1;
        if (add_i) mask_q <= mask_q | sel;
      end
    end
  end

  assign active_o = active_q;
  assign mask_o   = mask_q;
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W = 25,
  parameter int BLK_W  = 8,
  localparam int NUM_BLK = 1 << BLK_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [7:0]         data_i,
  input  logic               busy_i,
  input  cyc_t               cyc_i,
  input  logic               win_expire_i,
  input  logic [NUM_BLK-1:0] win_mask_i,
  output logic               win_start_o,
  output logic               win_add_o,
  output logic               win_cancel_o,
  output logic               cmd_valid_o,
  output logic [2:0]         cmd_op_o,
  output logic [ADDR_W-1:0]  cmd_addr_o,
  output logic [7:0]         cmd_data_o,
  output logic [NUM_BLK-1:0] cmd_mask_o,
  output logic               bypass_o,
  output logic               suspended_o
);
  seq_e state_q, state_d;
  logic byp_ret_q, byp_ret_d;
  logic susp_q, susp_d;
  logic emit;
  op_e  op_d;

  logic               valid_q;
  op_e                op_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [7:0]         data_q;
  logic [NUM_BLK-1:0] mask_q;

  always_comb begin
    state_d      = state_q;
    byp_ret_d    = byp_ret_q;
    susp_d       = susp_q;
    emit         = 1'b0;
    op_d         = OP_NONE;
    win_start_o  = 1'b0;
    win_add_o    = 1'b0;
    win_cancel_o = 1'b0;
    if (win_expire_i) begin
      emit    = 1'b1;
      op_d    = OP_BLOCK;
      state_d = byp_ret_q ? ST_BYP : ST_READ;
    end else if (wr_en_i) begin
      if (busy_i) begin
        if (cyc_i.d_susp && !susp_q) begin
          emit   = 1'b1;
          op_d   = OP_SUSP;
          susp_d = 1'b1;
        end
      end else if (cyc_i.d_reset) begin
        emit         = 1'b1;
        op_d         = OP_RESET;
        state_d      = ST_READ;
        win_cancel_o = 1'b1;
      end else begin
        unique case (state_q)
          ST_READ: begin
            if (susp_q && cyc_i.d_blk) begin
              emit   = 1'b1;
              op_d   = OP_RESUME;
              susp_d = 1'b0;
            end else if (cyc_i.key1) begin
              state_d = ST_U1;
            end
          end
          ST_U1: state_d = cyc_i.key2 ? ST_U2 : ST_READ;
          ST_U2: begin
            if (cyc_i.at_cmd && cyc_i.d_prog)        state_d = ST_PROG;
            else if (cyc_i.at_cmd && cyc_i.d_erase)  state_d = ST_E3;
            else if (cyc_i.at_cmd && cyc_i.d_bypass) state_d = ST_BYP;
            else                                     state_d = ST_READ;
          end
          ST_PROG: begin
            emit    = 1'b1;
            op_d    = OP_PROG;
            state_d = ST_READ;
          end
          ST_E3: state_d = cyc_i.key1 ? ST_E4 : ST_READ;
          ST_E4: state_d = cyc_i.key2 ? ST_E5 : ST_READ;
          ST_E5: begin
            if (cyc_i.at_cmd && cyc_i.d_chip) begin
              emit    = 1'b1;
              op_d    = OP_CHIP;
              state_d = ST_READ;
            end else if (cyc_i.d_blk) begin
              win_start_o = 1'b1;
              byp_ret_d   = 1'b0;
              state_d     = ST_BWIN;
            end else begin
              state_d = ST_READ;
            end
          end
          ST_BWIN: begin
            if (cyc_i.d_blk) begin
              win_add_o = 1'b1;
            end else begin
              win_cancel_o = 1'b1;
              state_d      = ST_READ;
            end
          end
          ST_BYP: begin
            if (cyc_i.d_prog)       state_d = ST_BPROG;
            else if (cyc_i.d_erase) state_d = ST_BERASE;
            else if (susp_q && cyc_i.d_blk) begin
              emit   = 1'b1;
              op_d   = OP_RESUME;
              susp_d = 1'b0;
            end else begin
              state_d = ST_READ;
            end
          end
          ST_BPROG: begin
            emit    = 1'b1;
            op_d    = OP_PROG;
            state_d = ST_BYP;
          end
          ST_BERASE: begin
            if (cyc_i.d_chip) begin
              emit    = 1'b1;
              op_d    = OP_CHIP;
              state_d = ST_BYP;
            end else if (cyc_i.d_blk) begin
              win_start_o = 1'b1;
              byp_ret_d   = 1'b1;
              state_d     = ST_BWIN;
            end else begin
              state_d = ST_READ;
            end
          end
          default: state_d = ST_READ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_READ;
      byp_ret_q <= 1'b0;
      susp_q    <= 1'b0;
      valid_q   <= 1'b0;
      op_q      <= OP_NONE;
      addr_q    <= '0;
      data_q    <= '0;
      mask_q    <= '0;
    end else begin
      state_q   <= state_d;
      byp_ret_q <= byp_ret_d;
      susp_q    <= susp_d;
      valid_q   <= emit;
      op_q      <= op_d;
      if (emit && op_d == OP_BLOCK) begin
        addr_q <= '0;
        data_q <= D_BLK;
        mask_q <= win_mask_i;
      end else if (emit) begin
        addr_q <= addr_i;
        data_q <= data_i;
        mask_q <= '0;
      end else begin
        mask_q <= '0;
      end
    end
  end

  assign cmd_valid_o = valid_q;
  assign cmd_op_o    = op_q;
  assign cmd_addr_o  = addr_q;
  assign cmd_data_o  = data_q;
  assign cmd_mask_o  = mask_q;
  assign suspended_o = susp_q;
  assign bypass_o    = (state_q == ST_BYP) || (state_q == ST_BPROG) ||
                       (state_q == ST_BERASE) || ((state_q == ST_BWIN) && byp_ret_q);
endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W  = 25,
  parameter int BLK_W   = 8,
  parameter int WIN_CYC = 64,
  localparam int NUM_BLK = 1 << BLK_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [7:0]         data_i,
  input  logic               busy_i,
  output logic               cmd_valid_o,
  output logic [2:0]         cmd_op_o,
  output logic [ADDR_W-1:0]  cmd_addr_o,
  output logic [7:0]         cmd_data_o,
  output logic [NUM_BLK-1:0] cmd_mask_o,
  output logic               bypass_o,
  output logic               suspended_o
);
  cyc_t               cyc;
  logic               win_start, win_add, win_cancel, win_active, win_expire;
  logic [NUM_BLK-1:0] win_mask;
  logic [BLK_W-1:0]   blk_idx;

  assign blk_idx = addr_i[ADDR_W-1 -: BLK_W];

  nor_cmd_classify u_classify (
    .addr_lo_i (addr_i[CMD_AW-1:0]),
    .data_i    (data_i),
    .cyc_o     (cyc)
  );

  nor_erase_window #(.BLK_W(BLK_W), .WIN_CYC(WIN_CYC)) u_window (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (win_start),
    .add_i    (win_add),
    .cancel_i (win_cancel),
    .hold_i   (busy_i),
    .blk_i    (blk_idx),
    .active_o (win_active),
    .expire_o (win_expire),
    .mask_o   (win_mask)
  );

  nor_cmd_seq #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .addr_i       (addr_i),
    .data_i       (data_i),
    .busy_i       (busy_i),
    .cyc_i        (cyc),
    .win_expire_i (win_expire && win_active),
    .win_mask_i   (win_mask),
    .win_start_o  (win_start),
    .win_add_o    (win_add),
    .win_cancel_o (win_cancel),
    .cmd_valid_o  (cmd_valid_o),
    .cmd_op_o     (cmd_op_o),
    .cmd_addr_o   (cmd_addr_o),
    .cmd_data_o   (cmd_data_o),
    .cmd_mask_o   (cmd_mask_o),
    .bypass_o     (bypass_o),
    .suspended_o  (suspended_o)
  );
endmodule

// File: rtl/nor_cmd_decoder_chk.sv
module nor_cmd_decoder_chk
  import nor_cmd_pkg::*;
#(
  parameter int NUM_BLK = 256
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic               busy_i,
  input logic               cmd_valid_o,
  input logic [2:0]         cmd_op_o,
  input logic [NUM_BLK-1:0] cmd_mask_o,
  input logic               bypass_o,
  input logic               suspended_o
);
  a_r10_busy_only_suspend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (!cmd_valid_o || cmd_op_o == OP_SUSP));

  a_r10_suspend_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_op_o == OP_SUSP) |-> suspended_o);

  a_r11_resume_needs_suspend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_op_o == OP_RESUME) |-> (!suspended_o && $past(suspended_o)));

  a_r9_reset_leaves_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_op_o == OP_RESET) |-> !bypass_o);

  a_r4_mask_on_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_op_o == OP_BLOCK) |-> ($countones(cmd_mask_o) > 0));

  a_r4_mask_zero_else: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_o && cmd_op_o == OP_BLOCK) |-> (cmd_mask_o == '0));

  a_r2_prog_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && (cmd_op_o == OP_PROG || cmd_op_o == OP_CHIP)) |-> $past(wr_en_i));
endmodule

bind nor_cmd_decoder nor_cmd_decoder_chk #(.NUM_BLK(NUM_BLK)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .busy_i      (busy_i),
  .cmd_valid_o (cmd_valid_o),
  .cmd_op_o    (cmd_op_o),
  .cmd_mask_o  (cmd_mask_o),
  .bypass_o    (bypass_o),
  .suspended_o (suspended_o)
);

// File: tb/nor_cmd_decoder_tb.sv
module nor_cmd_decoder_tb;
  import nor_cmd_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 25;
  localparam int BLK_W  = 8;
  localparam int WIN    = 16;
  localparam int NB     = 1 << BLK_W;

  logic clk, rst_ni, wr_en, busy;
  logic [ADDR_W-1:0] addr;
  logic [7:0] data;
  logic cmd_valid, bypass, suspended;
  logic [2:0] cmd_op;
  logic [ADDR_W-1:0] cmd_addr;
  logic [7:0] cmd_data;
  logic [NB-1:0] cmd_mask;

  nor_cmd_decoder #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .WIN_CYC(WIN)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr), .data_i(data),
    .busy_i(busy), .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op), .cmd_addr_o(cmd_addr),
    .cmd_data_o(cmd_data), .cmd_mask_o(cmd_mask), .bypass_o(bypass), .suspended_o(suspended)
  );

  typedef struct {
    logic [2:0]        op;
    logic [ADDR_W-1:0] a;
    logic [7:0]        d;
    logic [NB-1:0]     m;
    string             tag;
  } exp_t;

  exp_t exp_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(bit ok, string tag, logic [NB-1:0] act, logic [NB-1:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  task automatic push(logic [2:0] op, logic [ADDR_W-1:0] a, logic [7:0] d,
                      logic [NB-1:0] m, string tag);
    exp_t e;
    e.op = op; e.a = a; e.d = d; e.m = m; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: compare every pulse against the scoreboard
  always @(negedge clk) begin
    if (rst_ni && cmd_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected pulse", NB'({cmd_op, cmd_addr, cmd_data}), '0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk({cmd_op, cmd_addr, cmd_data} == {e.op, e.a, e.d}, e.tag,
            NB'({cmd_op, cmd_addr, cmd_data}), NB'({e.op, e.a, e.d}));
        chk(cmd_mask == e.m, {e.tag, " mask"}, cmd_mask, e.m);
      end
    end
  end

  function automatic logic [NB-1:0] bitm(int n);
    logic [NB-1:0] m;
    m = '0;
    m[n] = 1'b1;
    return m;
  endfunction

  function automatic logic [ADDR_W-1:0] baddr(int b, int off);
    return {b[BLK_W-1:0], 17'(off)};
  endfunction

  task automatic wr(logic [ADDR_W-1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock();
    wr(25'h0000AAA, 8'hAA);
    wr(25'h0000555, 8'h55);
  endtask

  task automatic enter_bypass();
    unlock();
    wr(25'h0000AAA, 8'h20);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired act=1 exp=0");
      summary();
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; wr_en = 1'b0; busy = 1'b0; addr = '0; data = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1
    chk(cmd_valid == 1'b0 && cmd_op == 3'd0, "R1 reset cmd", NB'({cmd_valid, cmd_op}), '0);
    chk(cmd_mask == '0, "R1 reset mask", cmd_mask, '0);
    chk({bypass, suspended} == 2'b00, "R1 reset flags", NB'({bypass, suspended}), '0);

    // R2 program, upper address bits ignored on unlock
    push(3'd1, 25'h0123456, 8'h5A, '0, "R2 program");
    wr(25'h1FF0AAA, 8'hAA);
    wr(25'h0AB0555, 8'h55);
    wr(25'h0000AAA, 8'hA0);
    wr(25'h0123456, 8'h5A);

    // R3 chip erase
    push(3'd2, 25'h0000AAA, 8'h10, '0, "R3 chip erase");
    unlock(); wr(25'h0000AAA, 8'h80); unlock(); wr(25'h0000AAA, 8'h10);

    // R4 single block erase
    push(3'd3, '0, 8'h30, bitm(5), "R4 block erase");
    unlock(); wr(25'h0000AAA, 8'h80); unlock(); wr(baddr(5, 'h123), 8'h30);
    repeat (WIN + 4) @(negedge clk);

    // R5 window boundaries
    push(3'd3, '0, 8'h30, bitm(7) | bitm(200) | bitm(255), "R5 multi block");
    unlock(); wr(25'h0000AAA, 8'h80); unlock();
    wr(baddr(7, 0), 8'h30);        // sampled at edge N
    wr(baddr(200, 'h40), 8'h30);   // edge N+2
    repeat (WIN - 5) @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = baddr(255, 1); data = 8'h30;  // edge N+WIN-1
    @(negedge clk);
    addr = baddr(9, 2);                                // edge N+WIN, too late
    chk(cmd_valid == 1'b0, "R5 no early pulse", NB'(cmd_valid), '0);
    @(negedge clk);
    wr_en = 1'b0;
    chk(cmd_valid == 1'b1, "R5 pulse at window end", NB'(cmd_valid), 1);
    wr(baddr(11, 0), 8'h30);       // after expiry: ignored
    repeat (4) @(negedge clk);

    // R6 invalid cycle returns to read
    wr(25'h0000AAA, 8'hAA);
    wr(25'h0000555, 8'h54);
    wr(25'h0000AAA, 8'hA0);
    wr(25'h0000777, 8'h12);
    push(3'd1, 25'h0000010, 8'h01, '0, "R6 program after abort");
    unlock(); wr(25'h0000AAA, 8'hA0); wr(25'h0000010, 8'h01);

    // R7 bypass program
    enter_bypass();
    chk(bypass == 1'b1, "R7 bypass entered", NB'(bypass), 1);
    push(3'd1, 25'h0100200, 8'hC3, '0, "R7 bypass program");
    wr(25'h0000000, 8'hA0); wr(25'h0100200, 8'hC3);
    push(3'd1, 25'h0100201, 8'h3C, '0, "R7 bypass program 2");
    wr(25'h0000123, 8'hA0); wr(25'h0100201, 8'h3C);
    chk(bypass == 1'b1, "R7 bypass kept", NB'(bypass), 1);

    // R8 bypass erase
    push(3'd2, 25'h0000042, 8'h10, '0, "R8 bypass chip erase");
    wr(25'h0000000, 8'h80); wr(25'h0000042, 8'h10);
    push(3'd3, '0, 8'h30, bitm(3), "R8 bypass block erase");
    wr(25'h0000000, 8'h80); wr(baddr(3, 'h77), 8'h30);
    repeat (WIN + 4) @(negedge clk);
    chk(bypass == 1'b1, "R8 back in bypass", NB'(bypass), 1);

    // R9 reset
    push(3'd6, 25'h0000321, 8'hF0, '0, "R9 reset in bypass");
    wr(25'h0000321, 8'hF0);
    chk(bypass == 1'b0, "R9 bypass cleared", NB'(bypass), 0);
    unlock();
    push(3'd6, 25'h0000007, 8'hF0, '0, "R9 reset mid sequence");
    wr(25'h0000007, 8'hF0);
    wr(25'h0000AAA, 8'hA0);
    wr(25'h0000300, 8'h11);
    unlock(); wr(25'h0000AAA, 8'h80); unlock(); wr(baddr(4, 0), 8'h30);
    push(3'd6, 25'h0000000, 8'hF0, '0, "R9 reset cancels window");
    wr(25'h0000000, 8'hF0);
    repeat (WIN + 4) @(negedge clk);

    // R10 busy: only suspend, sequence kept
    unlock(); wr(25'h0000AAA, 8'hA0);
    @(negedge clk) busy = 1'b1;
    wr(25'h0000100, 8'h77);
    wr(25'h0000000, 8'hF0);
    push(3'd4, 25'h0001234, 8'hB0, '0, "R10 suspend");
    wr(25'h0001234, 8'hB0);
    chk(suspended == 1'b1, "R10 suspended flag", NB'(suspended), 1);
    @(negedge clk) busy = 1'b0;
    push(3'd1, 25'h0ABCDE, 8'h5A, '0, "R10 sequence kept");
    wr(25'h0ABCDE, 8'h5A);

    // R11 resume
    wr(25'h0000000, 8'hB0);   // not busy: invalid, nothing
    push(3'd5, 25'h0000042, 8'h30, '0, "R11 resume");
    wr(25'h0000042, 8'h30);
    chk(suspended == 1'b0, "R11 suspended cleared", NB'(suspended), 0);
    wr(25'h0000042, 8'h30);

    // R12 invalid write leaves bypass
    enter_bypass();
    wr(25'h0000000, 8'h99);
    chk(bypass == 1'b0, "R12 bypass left", NB'(bypass), 0);
    wr(25'h0000000, 8'hA0);
    wr(25'h0000055, 8'h66);

    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, "R6 scoreboard drained", NB'(exp_q.size()), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule